// File: doc/BRIEF.md
# Programmable Frame Serial Port Engine

This block moves parallel words onto a serial data line and collects serial bits from a data input back into parallel words. It generates its own serial clock from the core clock. Each transfer is a sequence of bit periods built from four parameters: a start delay, a run of leading idle periods, the data bits themselves, and a run of trailing idle periods. A frame-sync pulse is placed independently of the data. Two more parameters set its delay from the end of the start delay and its width. Both are counted in bit periods.

In frame-master mode the block drives the frame pulse, and the pulse may rise in the middle of a word. In frame-slave mode an external frame input starts the transfer. A rising frame sampled at a period boundary marks that period as the frame position of the sequence. Words come from a transmit queue through a valid/pop pair, one word per transfer. Received words go out through a one-cycle valid pulse, right-justified. Parameter sets that break the timing rules raise an error flag, and no transfer starts.

Top module: `frame_serial_port`

## Requirements
- R1: `cfg_err` is high, and `tx_pop` never fires, when any of these holds: frame width is 0; frame width is at least lead+size+trail; frame delay plus frame width is less than start delay plus 1; size is 0 or above MAXW; frame delay is at least lead+size+trail; or frame-slave mode is selected with a nonzero start delay.
- R2: Number the bit periods of a transfer k=0,1,… with k=0 starting at the boundary where the word is popped. In master mode `frm_out` is high exactly for k from start delay+frame delay up to that value plus frame width minus 1, cut off at the last period of the transfer. In slave mode `frm_out` stays low.
- R3: Data bits go out MSB first on `sdo`, one per period, from k=start delay+lead for `cfg_size` periods. Bits of `tx_data` at positions `cfg_size` and above are ignored. `sdo` changes only at a period boundary.
- R4: Outside the data bits, `sdo` is 0, except from the frame rise period (start delay+frame delay) up to the first data period, where it holds the word's MSB. Between transfers `sdo` and `frm_out` are 0.
- R5: `sdi` is sampled at the rising edge of `sclk` in data periods only. After the last period, `rx_valid` is high for one cycle with the word right-justified in `rx_data` and zeros above bit `cfg_size`-1.
- R6: In slave mode `frm_in` is sampled at each period boundary. A low-to-high change makes the next period k=frame delay. A frame input that stays high without a new rise starts nothing.
- R7: In slave mode with frame delay greater than lead, the word is still transmitted but the received word is dropped (no `rx_valid`).
- R8: `tx_pop` is a single-cycle pulse, once per transfer. Configuration is captured at that point.
- R9: During and right after reset, `sclk`, `sdo`, `frm_out`, `rx_valid` and `tx_pop` are 0.
- R10: `sclk` has a period of 2*HALF core cycles. It is low for the first half of each bit period and high for the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_start_dly | input | CW | start delay in periods |
| cfg_lead | input | CW | idle periods before data |
| cfg_size | input | CW | data bits per word (1..MAXW) |
| cfg_trail | input | CW | idle periods after data |
| cfg_frm_dly | input | CW | frame delay after start delay |
| cfg_frm_wid | input | CW | frame width in periods |
| cfg_frm_slave | input | 1 | 1: frame is an input |
| cfg_err | output | 1 | illegal parameter set |
| tx_valid | input | 1 | transmit word available |
| tx_data | input | MAXW | transmit word, right-justified |
| tx_pop | output | 1 | word taken this cycle |
| rx_valid | output | 1 | received word strobe |
| rx_data | output | MAXW | received word, zero-filled |
| sclk | output | 1 | serial clock |
| frm_out | output | 1 | frame pulse in master mode |
| frm_in | input | 1 | frame input in slave mode |
| sdo | output | 1 | serial data out |
| sdi | input | 1 | serial data in |

## Verification
The bench targets a frame rising after the MSB has left, which a design coupling frame to data start would misplace. It also covers a frame longer than the remaining periods, which a design without truncation would leave high into idle. A slave frame arriving after the lead periods must yield no received word; a design ignoring that rule would emit a corrupt one. Further cases are a 32-bit word, a 1-bit word, a transmit word with set bits above the size, and `sdi` held high outside the data periods, which expose sign or junk leaking into `rx_data` or stray high bits on `sdo`. Each illegal parameter case is applied separately, and any start there counts as a failure.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
package fsp_pkg;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

   // legality of a timing set, all values in bit periods
   function automatic logic timing_legal(input int sdly, input int lead, input int size,
                                         input int trail, input int fdly, input int fwid,
                                         input logic slave, input int maxw);
      int body;
      body = lead + size + trail;
      timing_legal = (fwid >= 1) && (fwid < body) && (fdly + fwid >= sdly + 1) &&
                     (size >= 1) && (size <= maxw) && (fdly < body) &&
                     !(slave && (sdly != 0));
   endfunction

endpackage

// File: rtl/fsp_clkgen.sv
`timescale 1ns/1ps
module fsp_clkgen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic sclk,
   output logic rise_ev,
   output logic bnd_ev
);
   if (HALF < 1) begin : g_bad_half
      $error("HALF must be at least 1");
   end

   if (HALF == 1) begin : g_toggle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sclk <= 1'b0;
         else        sclk <= !sclk;
      end
      assign rise_ev = !sclk;
      assign bnd_ev  = sclk;
   end else begin : g_count
      localparam int PW = $clog2(2 * HALF);
      localparam logic [PW-1:0] RISE = PW'(HALF - 1);
      localparam logic [PW-1:0] LAST = PW'(2 * HALF - 1);
      logic [PW-1:0] ph;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph   <= '0;
            sclk <= 1'b0;
         end else begin
            ph <= (ph == LAST) ? '0 : ph + PW'(1);
            if (ph == RISE)      sclk <= 1'b1;
            else if (ph == LAST) sclk <= 1'b0;
         end
      end
      assign rise_ev = (ph == RISE);
      assign bnd_ev  = (ph == LAST);
   end

   // R10
   sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_ev |=> !sclk);
endmodule

// File: rtl/fsp_timing_check.sv
`timescale 1ns/1ps
module fsp_timing_check #(
   parameter int CW   = 6,
   parameter int MAXW = 32
) (
   input  logic [CW-1:0] sdly,
   input  logic [CW-1:0] lead,
   input  logic [CW-1:0] size,
   input  logic [CW-1:0] trail,
   input  logic [CW-1:0] fdly,
   input  logic [CW-1:0] fwid,
   input  logic          slave,
   output logic          err
);
   if ((1 << CW) <= MAXW) begin : g_bad_cw
      $error("CW too narrow to hold MAXW");
   end

   assign err = !fsp_pkg::timing_legal(int'(sdly), int'(lead), int'(size), int'(trail),
                                       int'(fdly), int'(fwid), slave, MAXW);
endmodule

// File: rtl/fsp_seq.sv
`timescale 1ns/1ps
module fsp_seq #(
   parameter int CW   = 6,
   parameter int MAXW = 32,
   localparam int KW  = CW + 2,
   localparam int SZ  = $clog2(MAXW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bnd_ev,
   input  logic [CW-1:0] sdly,
   input  logic [CW-1:0] lead,
   input  logic [CW-1:0] size,
   input  logic [CW-1:0] trail,
   input  logic [CW-1:0] fdly,
   input  logic [CW-1:0] fwid,
   input  logic          slave,
   input  logic          err,
   input  logic          tx_valid,
   input  logic          frm_in,
   output logic          tx_pop,
   output logic          done,
   output logic          in_data,
   output logic          pre_msb,
   output logic [SZ-1:0] bitpos,
   output logic          frm_out,
   output logic          keep,
   output logic [CW-1:0] size_q
);
   fsp_pkg::seq_state_e st;
   logic [KW-1:0] k;
   logic [CW-1:0] q_sdly, q_lead, q_trail, q_fdly, q_fwid;
   logic          q_slave, frm_smp;
   logic [KW-1:0] d_start, f_start, seq_len;
   logic          active, last, go;

   assign active  = (st == fsp_pkg::SEQ_RUN);
   assign d_start = KW'(q_sdly) + KW'(q_lead);
   assign f_start = KW'(q_sdly) + KW'(q_fdly);
   assign seq_len = d_start + KW'(size_q) + KW'(q_trail);
   assign last    = active && (k == seq_len - KW'(1));
   assign in_data = active && (k >= d_start) && (k < d_start + KW'(size_q));
   assign pre_msb = active && (k >= f_start) && (k < d_start);
   assign frm_out = active && !q_slave && (k >= f_start) && (k < f_start + KW'(q_fwid));
   assign keep    = !(q_slave && (q_fdly > q_lead));
   assign bitpos  = in_data ? SZ'(KW'(size_q) - KW'(1) - (k - d_start))
                            : SZ'(KW'(size_q) - KW'(1));
   assign go      = bnd_ev && !active && !err && tx_valid &&
                    (slave ? (frm_in && !frm_smp) : 1'b1);
   assign tx_pop  = go;
   assign done    = bnd_ev && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= fsp_pkg::SEQ_IDLE;
         k       <= '0;
         frm_smp <= 1'b0;
         q_sdly  <= '0;
         q_lead  <= '0;
         size_q  <= '0;
         q_trail <= '0;
         q_fdly  <= '0;
         q_fwid  <= '0;
         q_slave <= 1'b0;
      end else if (bnd_ev) begin
         frm_smp <= frm_in;
         if (go) begin
            st      <= fsp_pkg::SEQ_RUN;
            k       <= slave ? KW'(fdly) : '0;
            q_sdly  <= sdly;
            q_lead  <= lead;
            size_q  <= size;
            q_trail <= trail;
            q_fdly  <= fdly;
            q_fwid  <= fwid;
            q_slave <= slave;
         end else if (last) begin
            st <= fsp_pkg::SEQ_IDLE;
         end else if (active) begin
            k <= k + KW'(1);
         end
      end
   end

   // R8
   pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !tx_pop);
endmodule

// File: rtl/fsp_shift.sv
`timescale 1ns/1ps
module fsp_shift #(
   parameter int MAXW = 32,
   parameter int CW   = 6,
   localparam int SZ  = $clog2(MAXW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rise_ev,
   input  logic            load,
   input  logic [MAXW-1:0] tx_data,
   input  logic            in_data,
   input  logic            pre_msb,
   input  logic [SZ-1:0]   bitpos,
   input  logic            done,
   input  logic            keep,
   input  logic [CW-1:0]   size_q,
   input  logic            sdi,
   output logic            sdo,
   output logic            rx_valid,
   output logic [MAXW-1:0] rx_data
);
   if (MAXW < 2) begin : g_bad_w
      $error("MAXW must be at least 2");
   end

   logic [MAXW-1:0] word, rx_sh;

   assign sdo = (in_data || pre_msb) ? word[bitpos] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word     <= '0;
         rx_sh    <= '0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (load) begin
            word  <= tx_data;
            rx_sh <= '0;
         end else if (rise_ev && in_data) begin
            rx_sh <= {rx_sh[MAXW-2:0], sdi};
         end
         if (done) begin
            rx_valid <= keep;
            rx_data  <= rx_sh;
         end
      end
   end

   // R5
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R5
   rx_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rx_data >> size_q) == '0));
endmodule

// File: rtl/frame_serial_port.sv
`timescale 1ns/1ps
module frame_serial_port #(
   parameter int CW   = 6,
   parameter int MAXW = 32,
   parameter int HALF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   cfg_start_dly,
   input  logic [CW-1:0]   cfg_lead,
   input  logic [CW-1:0]   cfg_size,
   input  logic [CW-1:0]   cfg_trail,
   input  logic [CW-1:0]   cfg_frm_dly,
   input  logic [CW-1:0]   cfg_frm_wid,
   input  logic            cfg_frm_slave,
   output logic            cfg_err,
   input  logic            tx_valid,
   input  logic [MAXW-1:0] tx_data,
   output logic            tx_pop,
   output logic            rx_valid,
   output logic [MAXW-1:0] rx_data,
   output logic            sclk,
   output logic            frm_out,
   input  logic            frm_in,
   output logic            sdo,
   input  logic            sdi
);
   localparam int SZ = $clog2(MAXW);

   logic          rise_ev, bnd_ev, done, in_data, pre_msb, keep;
   logic [SZ-1:0] bitpos;
   logic [CW-1:0] size_q;

   fsp_clkgen #(.HALF(HALF)) i_clkgen (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_ev(rise_ev), .bnd_ev(bnd_ev));

   fsp_timing_check #(.CW(CW), .MAXW(MAXW)) i_check (
      .sdly(cfg_start_dly), .lead(cfg_lead), .size(cfg_size), .trail(cfg_trail),
      .fdly(cfg_frm_dly), .fwid(cfg_frm_wid), .slave(cfg_frm_slave), .err(cfg_err));

   fsp_seq #(.CW(CW), .MAXW(MAXW)) i_seq (
      .clk(clk), .rst_n(rst_n), .bnd_ev(bnd_ev),
      .sdly(cfg_start_dly), .lead(cfg_lead), .size(cfg_size), .trail(cfg_trail),
      .fdly(cfg_frm_dly), .fwid(cfg_frm_wid), .slave(cfg_frm_slave), .err(cfg_err),
      .tx_valid(tx_valid), .frm_in(frm_in), .tx_pop(tx_pop), .done(done),
      .in_data(in_data), .pre_msb(pre_msb), .bitpos(bitpos), .frm_out(frm_out),
      .keep(keep), .size_q(size_q));

   fsp_shift #(.MAXW(MAXW), .CW(CW)) i_shift (
      .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .load(tx_pop), .tx_data(tx_data),
      .in_data(in_data), .pre_msb(pre_msb), .bitpos(bitpos), .done(done), .keep(keep),
      .size_q(size_q), .sdi(sdi), .sdo(sdo), .rx_valid(rx_valid), .rx_data(rx_data));

   // R1
   err_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !tx_pop);
   // R3
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $past(bnd_ev));
   // R2
   frm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frm_out) |-> $past(bnd_ev));
endmodule

// File: tb/test_frame_serial_port.sv
`timescale 1ns/1ps
module test_frame_serial_port;
   localparam int CW = 6;
   localparam int MAXW = 32;

   typedef struct packed {
      logic        slave;
      logic [5:0]  sdly, lead, size, trail, fdly, fwid;
      logic [31:0] txw, rxw;
      logic        exp_err, exp_keep;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 6'd1, 6'd2, 6'd8,  6'd1, 6'd0, 6'd3, 32'hFFFF_FF5A, 32'hABCD_E1C3, 1'b0, 1'b1},
      '{1'b0, 6'd0, 6'd1, 6'd12, 6'd2, 6'd5, 6'd4, 32'h0000_0A5C, 32'hFFFF_F3E7, 1'b0, 1'b1},
      '{1'b0, 6'd0, 6'd0, 6'd32, 6'd0, 6'd0, 6'd1, 32'h8123_4567, 32'hC001_D00D, 1'b0, 1'b1},
      '{1'b0, 6'd2, 6'd1, 6'd1,  6'd1, 6'd1, 6'd2, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 1'b1},
      '{1'b1, 6'd0, 6'd3, 6'd6,  6'd1, 6'd2, 6'd2, 32'h0000_0025, 32'h0000_003A, 1'b0, 1'b1},
      '{1'b1, 6'd0, 6'd1, 6'd8,  6'd1, 6'd3, 6'd2, 32'h0000_00B4, 32'h0000_0077, 1'b0, 1'b0},
      '{1'b0, 6'd0, 6'd0, 6'd4,  6'd0, 6'd2, 6'd3, 32'h0000_0009, 32'h0000_0006, 1'b0, 1'b1},
      '{1'b0, 6'd0, 6'd1, 6'd8,  6'd1, 6'd1, 6'd0, 32'h0000_0011, 32'h0, 1'b1, 1'b0},
      '{1'b0, 6'd0, 6'd1, 6'd4,  6'd1, 6'd0, 6'd6, 32'h0000_0011, 32'h0, 1'b1, 1'b0},
      '{1'b0, 6'd5, 6'd1, 6'd4,  6'd1, 6'd1, 6'd2, 32'h0000_0011, 32'h0, 1'b1, 1'b0},
      '{1'b1, 6'd1, 6'd2, 6'd4,  6'd1, 6'd1, 6'd2, 32'h0000_0011, 32'h0, 1'b1, 1'b0},
      '{1'b0, 6'd0, 6'd1, 6'd33, 6'd1, 6'd0, 6'd2, 32'h0000_0011, 32'h0, 1'b1, 1'b0},
      '{1'b0, 6'd0, 6'd1, 6'd4,  6'd1, 6'd6, 6'd1, 32'h0000_0011, 32'h0, 1'b1, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [CW-1:0] c_sdly = '0, c_lead = '0, c_size = '0, c_trail = '0, c_fdly = '0, c_fwid = '0;
   logic c_slave = 1'b0, tx_valid = 1'b0, frm_in = 1'b0, sdi = 1'b0;
   logic [MAXW-1:0] tx_data = '0;
   logic cfg_err, tx_pop, rx_valid, sclk, frm_out, sdo;
   logic [MAXW-1:0] rx_data;
   int n_chk = 0, n_fail = 0, pop_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = !clk;

   frame_serial_port #(.CW(CW), .MAXW(MAXW), .HALF(2)) i_frame_serial_port (
      .clk(clk), .rst_n(rst_n), .cfg_start_dly(c_sdly), .cfg_lead(c_lead),
      .cfg_size(c_size), .cfg_trail(c_trail), .cfg_frm_dly(c_fdly), .cfg_frm_wid(c_fwid),
      .cfg_frm_slave(c_slave), .cfg_err(cfg_err), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk),
      .frm_out(frm_out), .frm_in(frm_in), .sdo(sdo), .sdi(sdi));

   always @(negedge clk) if (rst_n && tx_pop) pop_cnt++;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected serial output in period k (R3, R4)
   function automatic logic exp_sdo(input vec_t v, input int k);
      int d = int'(v.sdly) + int'(v.lead);
      int f = int'(v.sdly) + int'(v.fdly);
      if (k >= d && k < d + int'(v.size)) return v.txw[int'(v.size) - 1 - (k - d)];
      if (k >= f && k < d) return v.txw[int'(v.size) - 1];
      return 1'b0;
   endfunction

   // expected frame output in period k (R2)
   function automatic logic exp_frm(input vec_t v, input int k);
      int f = int'(v.sdly) + int'(v.fdly);
      return !v.slave && k >= f && k < f + int'(v.fwid);
   endfunction

   // bit to present on sdi in period k; 1 outside the data periods
   function automatic logic sdi_for(input vec_t v, input int k);
      int d = int'(v.sdly) + int'(v.lead);
      if (k >= d && k < d + int'(v.size)) return v.rxw[int'(v.size) - 1 - (k - d)];
      return 1'b1;
   endfunction

   function automatic logic [31:0] masked(input logic [31:0] w, input int n);
      if (n >= 32) return w;
      return w & ((32'd1 << n) - 32'd1);
   endfunction

   task automatic run_vec(input vec_t v);
      int len = int'(v.sdly) + int'(v.lead) + int'(v.size) + int'(v.trail);
      int kst = 0;
      int pops0;
      int w = 0;
      logic [63:0] as = '0, es = '0, af = '0, ef = '0;
      logic got = 1'b0;
      logic [31:0] rxd = '0;
      c_sdly = v.sdly; c_lead = v.lead; c_size = v.size; c_trail = v.trail;
      c_fdly = v.fdly; c_fwid = v.fwid; c_slave = v.slave;
      @(negedge clk);
      chk(cfg_err == v.exp_err, "R1 legality flag", 64'(cfg_err), 64'(v.exp_err));
      pops0 = pop_cnt;
      tx_data = v.txw;
      tx_valid = 1'b1;
      if (v.exp_err) begin
         repeat (40) @(negedge clk);
         tx_valid = 1'b0;
         chk(pop_cnt == pops0, "R1 no start on illegal set", 64'(pop_cnt - pops0), 64'd0);
         return;
      end
      if (!v.slave) begin
         do begin @(negedge clk); w++; end while (!tx_pop && w < 40);
         kst = 0;
      end else begin
         @(posedge sclk); #1;
         frm_in = 1'b1;
         kst = int'(v.fdly);
      end
      sdi = sdi_for(v, kst);
      for (int k = kst; k < len; k++) begin
         @(posedge sclk); #1;
         tx_valid = 1'b0;
         as[k] = sdo;      es[k] = exp_sdo(v, k);
         af[k] = frm_out;  ef[k] = exp_frm(v, k);
         if (v.slave && k >= int'(v.fdly) + int'(v.fwid) - 1) frm_in = 1'b0;
         sdi = sdi_for(v, k + 1);
      end
      frm_in = 1'b0;
      repeat (8) begin
         @(negedge clk);
         if (rx_valid && !got) begin got = 1'b1; rxd = rx_data; end
      end
      chk(as == es, v.slave ? "R3 R4 R6 slave sdo stream" : "R3 R4 sdo stream", as, es);
      chk(af == ef, v.slave ? "R2 slave frm_out low" : "R2 frame window", af, ef);
      chk(got == v.exp_keep, v.exp_keep ? "R5 rx_valid pulse" : "R7 slave late frame drops word",
          64'(got), 64'(v.exp_keep));
      if (v.exp_keep)
         chk(rxd == masked(v.rxw, int'(v.size)), "R5 rx word zero-filled", 64'(rxd),
             64'(masked(v.rxw, int'(v.size))));
      chk(pop_cnt == pops0 + 1, "R8 one pop per word", 64'(pop_cnt - pops0), 64'd1);
      chk(sdo == 1'b0 && frm_out == 1'b0, "R4 idle between transfers",
          64'({sdo, frm_out}), 64'd0);
   endtask

   initial begin
      repeat (1000 * 150) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      time t_a, t_b;
      int p0;
      repeat (4) @(negedge clk);
      chk(sclk == 1'b0 && sdo == 1'b0 && frm_out == 1'b0 && rx_valid == 1'b0,
          "R9 outputs in reset", 64'({sclk, sdo, frm_out, rx_valid}), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(tx_pop == 1'b0 && sdo == 1'b0 && frm_out == 1'b0 && rx_valid == 1'b0,
          "R9 outputs after reset", 64'({tx_pop, sdo, frm_out, rx_valid}), 64'd0);
      chk(cfg_err == 1'b1, "R1 all-zero set is illegal", 64'(cfg_err), 64'd1);

      // R10: sclk period and duty
      @(posedge sclk); t_a = $time;
      @(negedge sclk); t_b = $time;
      chk((t_b - t_a) == 10, "R10 sclk high half", 64'(t_b - t_a), 64'd10);
      @(posedge sclk);
      chk(($time - t_a) == 20, "R10 sclk period", 64'($time - t_a), 64'd20);

      // vector table
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R6: slave frame held high with no new rise starts nothing
      c_sdly = 6'd0; c_lead = 6'd3; c_size = 6'd6; c_trail = 6'd1;
      c_fdly = 6'd2; c_fwid = 6'd2; c_slave = 1'b1;
      @(posedge sclk); #1;
      frm_in = 1'b1;
      repeat (12) @(negedge clk);
      p0 = pop_cnt;
      tx_valid = 1'b1; tx_data = 32'h15;
      repeat (40) @(negedge clk);
      chk(pop_cnt == p0, "R6 held frame without rise ignored", 64'(pop_cnt - p0), 64'd0);
      chk(frm_out == 1'b0 && sdo == 1'b0, "R6 slave stays idle", 64'({frm_out, sdo}), 64'd0);
      tx_valid = 1'b0;
      frm_in = 1'b0;
      repeat (12) @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule